// File: doc/BRIEF.md
# Seven-Register ALU Datapath

This block is a single-cycle datapath built around seven general-purpose registers, a pair of source selectors, one shared arithmetic/logic unit and a destination write decoder. Each clock cycle a 14-bit control word is applied. It picks the two operands, picks one operation and optionally names a register that captures the result on the next rising edge.

Either operand can be a register or the external data input. The unit's result is always visible on the output bus, whether or not any register is written. With a pass-through operation and no destination, the block can therefore show any register or the input value on the output without changing state. A controller outside the block sequences control words to run register-transfer programs such as `R1 <- R2 - R3`.

Top module: `regfile_alu_path`

## Requirements
- R1: The control word is split, from the most significant bit down, into source-A select in bits 13:11, source-B select in bits 10:8, destination select in bits 7:5 and operation code in bits 4:0.
- R2: On either source select, code 0 routes the external input to that operand and codes 1 to 7 route register R1 to R7.
- R3: Destination code 0 writes no register. Codes 1 to 7 load R1 to R7 with the current result on the rising clock edge.
- R4: The output bus carries the unit's result for the current control word and operands within the same cycle, with no register in between.
- R5: Arithmetic codes: 00000 passes A, 00001 gives A+1, 00010 gives A+B, 00101 gives A-B and 00110 gives A-1. All wrap modulo 2^16.
- R6: Logic codes: 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B and 01110 gives the bitwise complement of A.
- R7: Code 10000 shifts A right by one and code 11000 shifts A left by one. The vacated bit is filled with 0.
- R8: Every other operation code yields zero, and that zero is still written to the selected destination.
- R9: A synchronous active-high reset clears R1 through R7 to zero.
- R10: A pass-A operation with destination code 0 shows the selected register or the input on the output and leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers load on its rising edge |
| rst | input | 1 | Synchronous active-high reset of R1..R7 |
| ctrl_word | input | 14 | Control word: source A, source B, destination, operation |
| ext_in | input | 16 | External data operand, selected by source code 0 |
| result_out | output | 16 | Combinational result of the unit |

## Verification
The hardest behaviour to observe is a write landing in exactly one register and nowhere else. From the ports, register contents can only be seen by routing them through the unit. For this reason, random control words run against a bench-side copy of all seven registers, and every later read of a register compares against that copy. Directed words cover the cases random stimulus rarely produces: identical sources for subtract and XOR, wrap at all-ones and at zero, shifts of a value with both end bits set, and a write of an undefined code's zero into a loaded register. A reset in the middle of the run is followed by a read of every register.

// File: rtl/rfpath_pkg.sv
package rfpath_pkg;

  localparam int CW_SEL_W = 3;
  localparam int CW_OP_W  = 5;
  localparam int CW_W     = 3 * CW_SEL_W + CW_OP_W;

  typedef enum logic [CW_OP_W-1:0] {
    OP_PASS_A = 5'b00000,
    OP_INC_A  = 5'b00001,
    OP_ADD    = 5'b00010,
    OP_SUB    = 5'b00101,
    OP_DEC_A  = 5'b00110,
    OP_AND    = 5'b01000,
    OP_OR     = 5'b01010,
    OP_XOR    = 5'b01100,
    OP_NOT_A  = 5'b01110,
    OP_SHR_A  = 5'b10000,
    OP_SHL_A  = 5'b11000
  } opr_e;

  typedef struct packed {
    logic [CW_SEL_W-1:0] sel_a;
    logic [CW_SEL_W-1:0] sel_b;
    logic [CW_SEL_W-1:0] sel_d;
    logic [CW_OP_W-1:0]  opr;
  } ctrl_t;

endpackage

// File: rtl/rfpath_wdec.sv
module rfpath_wdec #(
  parameter int SEL_W = 3,
  localparam int NREG = (1 << SEL_W) - 1
) (
  input  logic [SEL_W-1:0] sel_d,
  output logic [NREG-1:0]  wr_en
);

  // one enable per register; code 0 maps to no output
  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign wr_en[g] = (sel_d == SEL_W'(g + 1));
  end

endmodule

// File: rtl/rfpath_regbank.sv
module rfpath_regbank #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 3,
  localparam int NREG  = (1 << SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREG-1:0]   wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  sel_a,
  input  logic [SEL_W-1:0]  sel_b,
  input  logic [DATA_W-1:0] ext_in,
  output logic [DATA_W-1:0] src_a,
  output logic [DATA_W-1:0] src_b
);

  logic [DATA_W-1:0] store [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        store[g] <= '0;
      end else if (wr_en[g]) begin
        store[g] <= wr_data;
      end
    end
  end

  logic [SEL_W-1:0] idx_a;
  logic [SEL_W-1:0] idx_b;

  assign idx_a = sel_a - SEL_W'(1);
  assign idx_b = sel_b - SEL_W'(1);

  always_comb begin
    if (sel_a == '0) src_a = ext_in;
    else             src_a = store[idx_a];
    if (sel_b == '0) src_b = ext_in;
    else             src_b = store[idx_b];
  end

endmodule

// File: rtl/rfpath_alu.sv
module rfpath_alu
  import rfpath_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [CW_OP_W-1:0] opr,
  input  logic [DATA_W-1:0]  opa,
  input  logic [DATA_W-1:0]  opb,
  output logic [DATA_W-1:0]  res
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    case (opr)
      OP_PASS_A: res = opa;
      OP_INC_A:  res = opa + ONE;
      OP_ADD:    res = opa + opb;
      OP_SUB:    res = opa - opb;
      OP_DEC_A:  res = opa - ONE;
      OP_AND:    res = opa & opb;
      OP_OR:     res = opa | opb;
      OP_XOR:    res = opa ^ opb;
      OP_NOT_A:  res = ~opa;
      OP_SHR_A:  res = {1'b0, opa[DATA_W-1:1]};
      OP_SHL_A:  res = {opa[DATA_W-2:0], 1'b0};
      default:   res = '0;
    endcase
  end

endmodule

// File: rtl/regfile_alu_path.sv
module regfile_alu_path
  import rfpath_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW_W-1:0]   ctrl_word,
  input  logic [DATA_W-1:0] ext_in,
  output logic [DATA_W-1:0] result_out
);

  localparam int NREG = (1 << CW_SEL_W) - 1;

  ctrl_t             cw;
  logic [NREG-1:0]   wr_en;
  logic [DATA_W-1:0] bus_a;
  logic [DATA_W-1:0] bus_b;
  logic [DATA_W-1:0] alu_y;

  assign cw = ctrl_t'(ctrl_word);

  rfpath_wdec #(.SEL_W(CW_SEL_W)) u_wdec (
    .sel_d (cw.sel_d),
    .wr_en (wr_en)
  );

  rfpath_regbank #(.DATA_W(DATA_W), .SEL_W(CW_SEL_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (alu_y),
    .sel_a   (cw.sel_a),
    .sel_b   (cw.sel_b),
    .ext_in  (ext_in),
    .src_a   (bus_a),
    .src_b   (bus_b)
  );

  rfpath_alu #(.DATA_W(DATA_W)) u_alu (
    .opr (cw.opr),
    .opa (bus_a),
    .opb (bus_b),
    .res (alu_y)
  );

  assign result_out = alu_y;

endmodule

// File: rtl/rfpath_checker.sv
module rfpath_checker
  import rfpath_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int NREG  = (1 << CW_SEL_W) - 1
) (
  input logic              clk,
  input logic              rst,
  input logic [CW_W-1:0]   ctrl_word,
  input logic [DATA_W-1:0] ext_in,
  input logic [DATA_W-1:0] result_out,
  input logic [NREG-1:0]   wr_en
);

  ctrl_t c;
  assign c = ctrl_t'(ctrl_word);

  logic op_known;
  always_comb begin
    case (c.opr)
      OP_PASS_A, OP_INC_A, OP_ADD, OP_SUB, OP_DEC_A, OP_AND,
      OP_OR, OP_XOR, OP_NOT_A, OP_SHR_A, OP_SHL_A: op_known = 1'b1;
      default: op_known = 1'b0;
    endcase
  end

  p_one_target_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));

  p_no_dest_r3: assert property (@(posedge clk) disable iff (rst)
    (c.sel_d == '0) |-> (wr_en == '0));

  p_ext_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (c.sel_a == '0 && c.opr == OP_PASS_A) |-> (result_out == ext_in));

  p_self_sub_r5: assert property (@(posedge clk) disable iff (rst)
    (c.sel_a == c.sel_b && c.opr == OP_SUB) |-> (result_out == '0));

  p_self_xor_r6: assert property (@(posedge clk) disable iff (rst)
    (c.sel_a == c.sel_b && c.opr == OP_XOR) |-> (result_out == '0));

  p_undef_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !op_known |-> (result_out == '0));

endmodule

bind regfile_alu_path rfpath_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctrl_word  (ctrl_word),
  .ext_in     (ext_in),
  .result_out (result_out),
  .wr_en      (wr_en)
);

// File: tb/regfile_alu_path_test.sv
`timescale 1ns/1ps
module regfile_alu_path_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] ctrl_word = '0;
  logic [15:0] ext_in = '0;
  logic [15:0] result_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [15:0] model [1:7];

  always #2.5 clk = ~clk;

  regfile_alu_path uut (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word),
    .ext_in(ext_in), .result_out(result_out)
  );

  function automatic logic [15:0] ref_alu(input logic [4:0] op,
                                          input logic [15:0] a, input logic [15:0] b);
    case (op)
      5'b00000: return a;
      5'b00001: return a + 16'd1;
      5'b00010: return a + b;
      5'b00101: return a - b;
      5'b00110: return a - 16'd1;
      5'b01000: return a & b;
      5'b01010: return a | b;
      5'b01100: return a ^ b;
      5'b01110: return ~a;
      5'b10000: return a >> 1;
      5'b11000: return a << 1;
      default:  return 16'h0000;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110: return "R5";
      5'b01000, 5'b01010, 5'b01100, 5'b01110:           return "R6";
      5'b10000, 5'b11000:                               return "R7";
      default:                                          return "R8";
    endcase
  endfunction

  function automatic logic [13:0] mk(input int a, input int b, input int d,
                                     input logic [4:0] op);
    return {3'(a), 3'(b), 3'(d), op};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // apply one control word for one cycle, compare output, track writes
  task automatic step(input logic [13:0] cw, input logic [15:0] x, input string tag);
    logic [15:0] a, b, e;
    int sa, sb, sd;
    @(negedge clk);
    ctrl_word = cw;
    ext_in    = x;
    #1;
    sa = int'(cw[13:11]);
    sb = int'(cw[10:8]);
    sd = int'(cw[7:5]);
    a  = (sa == 0) ? x : model[sa];
    b  = (sb == 0) ? x : model[sb];
    e  = ref_alu(cw[4:0], a, b);
    check(tag, result_out, e);
    if (sd != 0) model[sd] = e;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    ctrl_word = mk(0, 0, 3, 5'b00000);
    ext_in = 16'hDEAD;
    @(negedge clk);
    rst = 1'b0;
    ctrl_word = '0;
    for (int k = 1; k <= 7; k++) model[k] = '0;
  endtask

  task automatic read_all(input string tag);
    for (int k = 1; k <= 7; k++) step(mk(k, 0, 0, 5'b00000), 16'h5A5A, tag);
  endtask

  logic [4:0] ops [11] = '{5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110,
                           5'b01000, 5'b01010, 5'b01100, 5'b01110, 5'b10000, 5'b11000};

  initial begin
    void'($urandom(32'd2024));
    for (int k = 1; k <= 7; k++) model[k] = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R9: registers start at zero
    read_all("R9");

    // R3/R2: load each register from the input
    for (int k = 1; k <= 7; k++) step(mk(0, 0, k, 5'b00000), 16'(k * 16'h1111), "R3");
    read_all("R2");

    // R1 field layout example: R1 <- R2 - R3
    step(14'b010_011_001_00101, 16'h0, "R1");
    step(mk(1, 0, 0, 5'b00000), 16'h0, "R1");
    // R6: R5 xor R5 clears R5
    step(14'b101_101_101_01100, 16'h0, "R6");
    step(mk(5, 0, 0, 5'b00000), 16'hFFFF, "R6");

    // R5 wrap corners
    step(mk(0, 0, 6, 5'b00001), 16'hFFFF, "R5");
    step(mk(0, 0, 7, 5'b00110), 16'h0000, "R5");
    step(mk(6, 7, 0, 5'b00010), 16'h0, "R5");
    // R7 shifts of 8001
    step(mk(0, 0, 0, 5'b10000), 16'h8001, "R7");
    step(mk(0, 0, 0, 5'b11000), 16'h8001, "R7");
    // R8: undefined code writes zero into loaded R4
    step(mk(0, 0, 4, 5'b00000), 16'hBEEF, "R8");
    step(mk(0, 0, 4, 5'b10101), 16'h1234, "R8");
    step(mk(4, 0, 0, 5'b00000), 16'h0, "R8");
    // R10: pass with no destination then all registers unchanged
    step(mk(2, 0, 0, 5'b00000), 16'hAAAA, "R10");
    step(mk(0, 0, 0, 5'b00000), 16'h7777, "R10");
    read_all("R10");
    // R4: output follows inputs within the cycle
    step(mk(0, 0, 0, 5'b01110), 16'h0F0F, "R4");

    // random mix
    for (int i = 0; i < 500; i++) begin
      logic [4:0] op;
      op = ((($urandom % 8)) == 0) ? 5'($urandom) : ops[$urandom % 11];
      step(mk($urandom % 8, $urandom % 8, $urandom % 8, op), 16'($urandom), tag_of(op));
    end
    read_all("R3");

    // R9 mid-run reset
    do_reset();
    read_all("R9");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule